// File: doc/BRIEF.md
# Palette Color-Map Loader

This block holds a 256-entry color palette split into three 8-bit tables (red, green, blue) and gives it two faces. On the host face, software first writes an index through an index strobe. It then pushes color components through a single data strobe. An internal sequencer steers each component byte into the red, green or blue table of the current entry. After the blue byte it moves on to the next entry by itself, so a whole palette can be streamed with no further index writes.

A data write is either one byte wide or a full 32-bit word. A word carries four component bytes, most significant first, and takes four clock cycles to commit. While it drains, `busy` is high and any new host strobe is dropped. Each accepted data write raises a one-cycle `refresh` pulse, which asks the display side to redraw the whole screen. On the pixel face, an 8-bit index is looked up with one cycle of latency and comes back as a packed 24-bit RGB word.

Top module: `pal_loader`

## Requirements
- R1: Synchronous active-high `rst` clears every entry of all three tables to zero, sets the index to 0, sets the component sequence to red, and drives `busy`, `refresh` and `pix_rgb` to zero.
- R2: An accepted index write (`idx_wr` high while `busy` is low) loads `wdata[7:0]` as the current index and returns the sequence to red, even in the middle of a triplet.
- R3: A byte-wide data write (`cmap_wr` high, `cmap_wide` low, `busy` low, `idx_wr` low) stores `wdata[7:0]` into the table the sequence points at, and the sequence runs red, then green, then blue.
- R4: Storing a blue byte advances the index by one modulo 256 (255 wraps to 0) and returns the sequence to red.
- R5: A word-wide data write (`cmap_wide` high) stores `wdata[31:24]`, `wdata[23:16]`, `wdata[15:8]` and `wdata[7:0]` as four successive components, one per cycle, starting in the accept cycle. `busy` is high for exactly the three cycles after the accept edge.
- R6: While `busy` is high, `idx_wr` and `cmap_wr` are ignored: palette contents, index and sequence are unchanged by them.
- R7: When `idx_wr` and `cmap_wr` are high in the same cycle, the index write wins and the data write is dropped: nothing is stored and no `refresh` pulse follows.
- R8: `pix_rgb` shows the entry addressed by `pix_idx` one clock later, with red in bits 23:16, green in 15:8 and blue in 7:0. A lookup that hits an entry being written at the same edge returns the old contents.
- R9: `refresh` is high for exactly one cycle following each accepted data write, whether byte or word wide.
- R10: `host_rdata` always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Index register write strobe |
| cmap_wr | input | 1 | Color-map data write strobe |
| cmap_wide | input | 1 | 1: data write is a 32-bit word, 0: a single byte |
| wdata | input | 32 | Host write data |
| busy | output | 1 | A word write is still draining; host strobes are ignored |
| refresh | output | 1 | One-cycle full-redraw request after a data write |
| host_rdata | output | 32 | Host read data of both registers (always zero) |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Looked-up color, red/green/blue packed high to low |

## Verification
Two pairs of functions can fall in the same cycle. The first is an index write arriving together with a data write. The bench raises both strobes at one edge, then checks that `refresh` stays low and that the following byte lands in the red table of the newly written index. The second is a pixel lookup of the exact entry that a byte write is updating. The bench aims `pix_idx` at that entry during the write cycle and expects the pre-write color one cycle later, then the new color a cycle after that. Strobes raised during a word drain are also probed, and are judged by sweeping the whole palette afterwards against an arithmetic model.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    localparam int unsigned NUM_COMPS = 3;

    function automatic comp_e comp_after(input comp_e c);
        case (c)
            COMP_RED:   return COMP_GREEN;
            COMP_GREEN: return COMP_BLUE;
            default:    return COMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/pal_feeder.sv
module pal_feeder #(
    parameter int unsigned COMP_W = 8,
    parameter int unsigned LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      idx_wr,
    input  logic                      cmap_wr,
    input  logic                      wide,
    input  logic [LANES*COMP_W-1:0]   wdata,
    output logic                      idx_ld,
    output logic                      accept,
    output logic                      byte_vld,
    output logic [COMP_W-1:0]         byte_val,
    output logic                      busy
);
    localparam int unsigned WORD_W = LANES * COMP_W;
    localparam int unsigned REST_W = (LANES - 1) * COMP_W;
    localparam int unsigned CNT_W  = $clog2(LANES);

    logic [REST_W-1:0] rest_q;
    logic [CNT_W-1:0]  left_q;

    assign busy   = (left_q != '0);
    assign idx_ld = idx_wr && !busy;
    assign accept = cmap_wr && !idx_wr && !busy;

    always_comb begin
        byte_vld = 1'b0;
        byte_val = '0;
        if (busy) begin
            byte_vld = 1'b1;
            byte_val = rest_q[REST_W-1 -: COMP_W];
        end else if (accept) begin
            byte_vld = 1'b1;
            byte_val = wide ? wdata[WORD_W-1 -: COMP_W] : wdata[COMP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rest_q <= '0;
            left_q <= '0;
        end else if (busy) begin
            rest_q <= rest_q << COMP_W;
            left_q <= left_q - 1'b1;
        end else if (accept && wide) begin
            rest_q <= wdata[REST_W-1:0];
            left_q <= CNT_W'(LANES - 1);
        end
    end

    // R5: a drain only starts from an accepted word write
    assert_drain_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmap_wr && wide && !idx_wr));

    // R6: the last drain cycle always ends the busy window
    assert_drain_end_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && left_q == CNT_W'(1)) |=> !busy);

endmodule

// File: rtl/pal_sequencer.sv
module pal_sequencer
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_ld,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             byte_vld,
    output logic [IDX_W-1:0] wr_idx,
    output comp_e            comp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            comp   <= COMP_RED;
        end else if (idx_ld) begin
            wr_idx <= idx_val;
            comp   <= COMP_RED;
        end else if (byte_vld) begin
            comp <= comp_after(comp);
            if (comp == COMP_BLUE) begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    // R2: an index load lands and restarts at red
    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        idx_ld |=> (wr_idx == $past(idx_val) && comp == COMP_RED));

    // R4: a blue store steps the index with wrap and returns to red
    assert_blue_step_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !idx_ld && comp == COMP_BLUE)
            |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1) && comp == COMP_RED));

    // R3: the sequence never reaches an unused code
    assert_comp_legal_R3: assert property (@(posedge clk) disable iff (rst)
        comp != comp_e'(2'd3));

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_COMPS-1:0]          we,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [COMP_W-1:0]             wr_val,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [NUM_COMPS*COMP_W-1:0]   rd_rgb
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    for (genvar c = 0; c < NUM_COMPS; c++) begin : g_table
        logic [COMP_W-1:0] tab [DEPTH];
        logic [COMP_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int e = 0; e < DEPTH; e++) begin
                    tab[e] <= '0;
                end
                rd_q <= '0;
            end else begin
                if (we[c]) begin
                    tab[wr_idx] <= wr_val;
                end
                rd_q <= tab[rd_idx];
            end
        end

        assign rd_rgb[(NUM_COMPS-c)*COMP_W-1 -: COMP_W] = rd_q;
    end

    // R1: the lookup register comes out of reset cleared
    assert_lookup_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> rd_rgb == '0);

    // R3: at most one table takes a byte per cycle
    assert_one_table_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned LANES  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          idx_wr,
    input  logic                          cmap_wr,
    input  logic                          cmap_wide,
    input  logic [LANES*COMP_W-1:0]       wdata,
    output logic                          busy,
    output logic                          refresh,
    output logic [LANES*COMP_W-1:0]       host_rdata,
    input  logic [IDX_W-1:0]              pix_idx,
    output logic [NUM_COMPS*COMP_W-1:0]   pix_rgb
);
    logic                 idx_ld;
    logic                 accept;
    logic                 byte_vld;
    logic [COMP_W-1:0]    byte_val;
    logic [IDX_W-1:0]     wr_idx;
    comp_e                comp;
    logic [NUM_COMPS-1:0] we;

    pal_feeder #(.COMP_W(COMP_W), .LANES(LANES)) u_feeder (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (idx_wr),
        .cmap_wr  (cmap_wr),
        .wide     (cmap_wide),
        .wdata    (wdata),
        .idx_ld   (idx_ld),
        .accept   (accept),
        .byte_vld (byte_vld),
        .byte_val (byte_val),
        .busy     (busy)
    );

    pal_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .idx_ld   (idx_ld),
        .idx_val  (wdata[IDX_W-1:0]),
        .byte_vld (byte_vld),
        .wr_idx   (wr_idx),
        .comp     (comp)
    );

    always_comb begin
        for (int c = 0; c < NUM_COMPS; c++) begin
            we[c] = byte_vld && (comp == comp_e'(c));
        end
    end

    pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .wr_idx (wr_idx),
        .wr_val (byte_val),
        .rd_idx (pix_idx),
        .rd_rgb (pix_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            refresh <= 1'b0;
        end else begin
            refresh <= accept;
        end
    end

    assign host_rdata = '0;

    // R9: a refresh pulse follows only an accepted data write
    assert_refresh_cause_R9: assert property (@(posedge clk) disable iff (rst)
        refresh |-> $past(cmap_wr && !idx_wr && !busy));

    // R7: a colliding index write suppresses the refresh
    assert_collide_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && cmap_wr && !busy) |=> !refresh);

    // R6: a strobe during a drain never raises refresh
    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> !refresh);

endmodule

// File: tb/test_pal_loader.sv
module test_pal_loader;
    logic        clk = 1'b0;
    logic        rst;
    logic        idx_wr, cmap_wr, cmap_wide;
    logic [31:0] wdata;
    logic        busy, refresh;
    logic [31:0] host_rdata;
    logic [7:0]  pix_idx;
    logic [23:0] pix_rgb;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    int         m_idx;
    int         m_comp;

    always #10 clk = ~clk;

    pal_loader i_pal_loader (
        .clk        (clk),
        .rst        (rst),
        .idx_wr     (idx_wr),
        .cmap_wr    (cmap_wr),
        .cmap_wide  (cmap_wide),
        .wdata      (wdata),
        .busy       (busy),
        .refresh    (refresh),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = 8'h00; m_g[i] = 8'h00; m_b[i] = 8'h00;
        end
        m_idx = 0; m_comp = 0;
    endtask

    task automatic model_put(input logic [7:0] v);
        case (m_comp)
            0: m_r[m_idx] = v;
            1: m_g[m_idx] = v;
            default: m_b[m_idx] = v;
        endcase
        if (m_comp == 2) begin
            m_idx  = (m_idx + 1) % 256;
            m_comp = 0;
        end else begin
            m_comp++;
        end
    endtask

    function automatic logic [31:0] exp_rgb(input int i);
        return {8'h00, m_r[i], m_g[i], m_b[i]};
    endfunction

    task automatic host_idx(input logic [7:0] v);
        idx_wr = 1'b1; wdata = {24'h0, v};
        @(negedge clk);
        idx_wr = 1'b0;
        m_idx = v; m_comp = 0;
        check("R9 no refresh after index write", {31'h0, refresh}, 32'h0);
    endtask

    task automatic wr_byte(input logic [7:0] v);
        cmap_wr = 1'b1; cmap_wide = 1'b0; wdata = {24'h0, v};
        @(negedge clk);
        cmap_wr = 1'b0;
        model_put(v);
        check("R9 refresh after byte write", {31'h0, refresh}, 32'h1);
    endtask

    task automatic wr_word(input logic [31:0] w, input bit probe);
        cmap_wr = 1'b1; cmap_wide = 1'b1; wdata = w;
        @(negedge clk);
        cmap_wr = 1'b0; cmap_wide = 1'b0;
        check("R5 busy after word accept", {31'h0, busy}, 32'h1);
        check("R9 refresh after word write", {31'h0, refresh}, 32'h1);
        for (int j = 1; j <= 3; j++) begin
            if (probe && j == 1) begin
                idx_wr = 1'b1; cmap_wr = 1'b1; wdata = 32'h0000_0055;
            end
            if (probe && j == 2) begin
                cmap_wr = 1'b1; cmap_wide = 1'b1; wdata = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            idx_wr = 1'b0; cmap_wr = 1'b0; cmap_wide = 1'b0;
            check("R5 busy window", {31'h0, busy}, (j < 3) ? 32'h1 : 32'h0);
            check("R6 no refresh while draining", {31'h0, refresh}, 32'h0);
        end
        for (int k = 3; k >= 0; k--) model_put(w[k*8 +: 8]);
    endtask

    task automatic look(input string req, input int i);
        pix_idx = i[7:0];
        @(negedge clk);
        check(req, {8'h0, pix_rgb}, exp_rgb(i));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 256; i++) look(req, i);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idx_wr = 1'b0; cmap_wr = 1'b0; cmap_wide = 1'b0;
        wdata = 32'h0; pix_idx = 8'h0;
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'h0, busy}, 32'h0);
        check("R1 refresh in reset", {31'h0, refresh}, 32'h0);
        check("R1 pix_rgb in reset", {8'h0, pix_rgb}, 32'h0);
        check("R10 host_rdata", host_rdata, 32'h0);
        rst = 1'b0;
        sweep("R1 table clear");

        // R3 R4: stream the whole palette byte by byte, index wraps at the end
        host_idx(8'h00);
        for (int k = 0; k < 768; k++) wr_byte(8'((k * 7 + (k % 3) * 85 + 3) & 255));
        sweep("R3 R4 R8 byte fill");
        wr_byte(8'hC3);
        look("R4 wrap to entry 0", 0);

        // R2: index write mid triplet restarts at red
        host_idx(8'd10); wr_byte(8'hA1); wr_byte(8'hA2);
        host_idx(8'd20); wr_byte(8'hB1);
        look("R2 partial triplet", 10);
        look("R2 restart red", 20);

        // R5 R6: word writes across the wrap, with strobes during a drain
        host_idx(8'd254);
        wr_word(32'h1122_3344, 1'b1);
        wr_word(32'h5566_7788, 1'b0);
        wr_word(32'h99AA_BBCC, 1'b1);
        sweep("R5 R6 word writes");
        check("R10 host_rdata after writes", host_rdata, 32'h0);

        // R5: word starting in the green phase
        host_idx(8'd40); wr_byte(8'h0F);
        wr_word(32'hF0E1_D2C3, 1'b0);
        look("R5 green phase 40", 40);
        look("R5 green phase 41", 41);

        // R7: index and data strobes in the same cycle
        idx_wr = 1'b1; cmap_wr = 1'b1; wdata = 32'h0000_0064;
        @(negedge clk);
        idx_wr = 1'b0; cmap_wr = 1'b0;
        m_idx = 100; m_comp = 0;
        check("R7 no refresh on collision", {31'h0, refresh}, 32'h0);
        wr_byte(8'h5A);
        look("R7 index wins", 100);

        // R8: lookup of the entry being written sees the old value
        begin
            logic [31:0] old_v;
            old_v = exp_rgb(100);
            pix_idx = 8'd100;
            cmap_wr = 1'b1; cmap_wide = 1'b0; wdata = 32'h0000_0077;
            @(negedge clk);
            cmap_wr = 1'b0;
            model_put(8'h77);
            check("R8 read before write", {8'h0, pix_rgb}, old_v);
            @(negedge clk);
            check("R8 new value next cycle", {8'h0, pix_rgb}, exp_rgb(100));
        end

        // R1: reset clears everything again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        sweep("R1 clear after reset");
        wr_byte(8'h3C);
        look("R1 sequence at entry 0 red", 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule